// File: doc/BRIEF.md
# Serial configuration bit writer

This block is the host side of a four-wire link to a metering peripheral whose configuration and mode bits are set one at a time. Each command names one bit by its 7-bit address and carries the value to write. The block frames a burst on the link: it pulls the select line low, then the direction strobe low to put the peripheral's data pin into input mode. It then shifts one byte per command out on a slow clock whose rate is set by a divider and whose idle level is set by a polarity input. A precharge byte of all ones can be sent in place of a bit write.

Commands enter through a valid/ready port. `cmd_ready` is raised for one cycle at each byte boundary of an open burst, and never at any other time. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. The host must hold `cmd_valid` and the command fields steady until that cycle. If no command is waiting at a boundary, the burst is closed in a fixed order with programmable hold times. An abort input drops the link back to idle at once.

Top module: `cfg_bit_writer`

## Requirements
- R1: After reset and whenever no burst is open, `link_cs_n`=1, `link_strb`=1, `link_sclk` sits at its idle level, `link_sdo_oe`=0, `busy`=0 and `cmd_ready`=0.
- R2: A command byte is `{cmd_value, cmd_addr[6:0]}`, sent most significant bit first (value 1 to address 47 gives 0xAF).
- R3: Each byte takes exactly eight clock pulses. The peripheral captures on the return of `link_sclk` to its idle level, and the eighth pulse is the execute strobe. `link_sdo` changes only as the clock leaves idle, so it is stable at every capture.
- R4: A burst opens with `link_cs_n` falling, then `link_strb` falling max(`cfg_gap`,1) cycles later. The clock first leaves idle one cycle after that gap has passed again.
- R5: `link_sdo_oe` is high only while both `link_cs_n` and `link_strb` are low.
- R6: Each clock pulse holds the active level for max(`cfg_half`,1) cycles, then the idle level for the same count.
- R7: Commands accepted at successive byte boundaries go out within a single low period of `link_cs_n`.
- R8: With `cmd_precharge`=1 the byte sent is 0xFF, whatever the value and address fields hold.
- R9: `cfg_clk_inv`=0 makes the clock idle high; `cfg_clk_inv`=1 makes it idle low. Capture stays on the return to idle.
- R10: A burst closes with `link_strb` rising. `link_cs_n` rises max(`cfg_gap`,1) cycles later, and `busy` falls the same number of cycles after that.
- R11: An `abort` sampled during a burst sets `link_cs_n`=1, `link_strb`=1, `link_sdo_oe`=0 and the clock idle by the next cycle. The unfinished byte is never completed, and `busy` falls max(`cfg_gap`,1) cycles later.
- R12: `cmd_ready` is high only at a byte boundary inside an open burst, with both link lines low and the clock idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command taken this cycle if valid |
| cmd_value | input | 1 | Bit value to write |
| cmd_addr | input | 7 | Destination bit address |
| cmd_precharge | input | 1 | Send 0xFF instead of a write |
| cfg_half | input | HALF_W | Cycles per clock half-period |
| cfg_gap | input | GAP_W | Minimum cycles between control-line steps |
| cfg_clk_inv | input | 1 | Clock idle level is low when 1 |
| abort | input | 1 | Release the link immediately |
| busy | output | 1 | A burst or its recovery is in progress |
| link_cs_n | output | 1 | Link select, active low |
| link_strb | output | 1 | Direction strobe, low selects write |
| link_sclk | output | 1 | Link clock |
| link_sdo | output | 1 | Serial data toward the peripheral |
| link_sdo_oe | output | 1 | Drive enable for the data line |

## Verification
The bench checks the bytes a model of the peripheral rebuilds from capture edges against the encoding. A bit-order or precharge error shows up as a wrong byte. An extra or missing pulse shows up as a shifted byte or a wrong pulse count. The spacing of select, strobe and clock edges at both ends of a burst is measured in cycles. A design that swaps the closing order, or skips a hold, moves those numbers. Three commands are queued back to back and must share one select period; a design that closes between bytes shows extra select falls. The bench aborts a burst in the middle of a byte. A design that finishes the byte, or leaves the data driver on, leaves a completed byte or a driven line behind.

// File: rtl/cbw_pkg.sv
package cbw_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = ADDR_W + 1;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SEL,
    ST_WMODE,
    ST_LOAD,
    ST_ACT,
    ST_REST,
    ST_UNSTRB,
    ST_DESEL,
    ST_RECOVER
  } link_state_e;
endpackage

// File: rtl/cbw_hold_timer.sv
module cbw_hold_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         expired
);
  logic [W-1:0] cnt;

  // A state that loads the timer on entry lasts max(len,1) cycles.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= (len == '0) ? '0 : len - W'(1);
    end else if (cnt != '0) begin
      cnt <= cnt - W'(1);
    end
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/cbw_shifter.sv
module cbw_shifter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] din,
  input  logic             step,
  output logic             msb,
  output logic             last
);
  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  logic [WIDTH-1:0] sr;
  logic [CW-1:0]    cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '0;
      cnt <= '0;
    end else if (load) begin
      sr  <= din;
      cnt <= '0;
    end else if (step) begin
      sr  <= {sr[WIDTH-2:0], 1'b0};
      cnt <= cnt + CW'(1);
    end
  end

  assign msb  = sr[WIDTH-1];
  assign last = (cnt == CW'(WIDTH - 1));
endmodule

// File: rtl/cbw_seq.sv
module cbw_seq
  import cbw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic        abort,
  input  logic        gap_done,
  input  logic        half_done,
  input  logic        last_bit,
  output link_state_e st,
  output logic        gap_load,
  output logic        half_load,
  output logic        sh_load,
  output logic        sh_step,
  output logic        cmd_ready
);
  link_state_e nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nxt;
  end

  always_comb begin
    nxt       = st;
    gap_load  = 1'b0;
    half_load = 1'b0;
    sh_load   = 1'b0;
    sh_step   = 1'b0;
    cmd_ready = (st == ST_LOAD) && !abort;
    if (abort && st != ST_IDLE && st != ST_RECOVER) begin
      nxt      = ST_RECOVER;
      gap_load = 1'b1;
    end else begin
      unique case (st)
        ST_IDLE: if (cmd_valid) begin
          nxt      = ST_SEL;
          gap_load = 1'b1;
        end
        ST_SEL: if (gap_done) begin
          nxt      = ST_WMODE;
          gap_load = 1'b1;
        end
        ST_WMODE: if (gap_done) nxt = ST_LOAD;
        ST_LOAD: begin
          if (cmd_valid) begin
            sh_load   = 1'b1;
            half_load = 1'b1;
            nxt       = ST_ACT;
          end else begin
            gap_load = 1'b1;
            nxt      = ST_UNSTRB;
          end
        end
        ST_ACT: if (half_done) begin
          half_load = 1'b1;
          nxt       = ST_REST;
        end
        ST_REST: if (half_done) begin
          if (last_bit) begin
            nxt = ST_LOAD;
          end else begin
            sh_step   = 1'b1;
            half_load = 1'b1;
            nxt       = ST_ACT;
          end
        end
        ST_UNSTRB: if (gap_done) begin
          gap_load = 1'b1;
          nxt      = ST_DESEL;
        end
        ST_DESEL:   if (gap_done) nxt = ST_IDLE;
        ST_RECOVER: if (gap_done) nxt = ST_IDLE;
        default:    nxt = ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_bit_writer.sv
module cfg_bit_writer
  import cbw_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int GAP_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic                cmd_value,
  input  logic [ADDR_W-1:0]   cmd_addr,
  input  logic                cmd_precharge,
  input  logic [HALF_W-1:0]   cfg_half,
  input  logic [GAP_W-1:0]    cfg_gap,
  input  logic                cfg_clk_inv,
  input  logic                abort,
  output logic                busy,
  output logic                link_cs_n,
  output logic                link_strb,
  output logic                link_sclk,
  output logic                link_sdo,
  output logic                link_sdo_oe
);
  link_state_e        st;
  logic               gap_load, half_load, gap_done, half_done;
  logic               sh_load, sh_step, sh_msb, sh_last;
  logic [BYTE_W-1:0]  cmd_byte;
  logic               idle_lvl, selected, wmode, shifting;

  assign cmd_byte = cmd_precharge ? {BYTE_W{1'b1}} : {cmd_value, cmd_addr};

  cbw_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .abort     (abort),
    .gap_done  (gap_done),
    .half_done (half_done),
    .last_bit  (sh_last),
    .st        (st),
    .gap_load  (gap_load),
    .half_load (half_load),
    .sh_load   (sh_load),
    .sh_step   (sh_step),
    .cmd_ready (cmd_ready)
  );

  cbw_hold_timer #(.W(GAP_W)) u_gap_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (gap_load),
    .len     (cfg_gap),
    .expired (gap_done)
  );

  cbw_hold_timer #(.W(HALF_W)) u_half_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (half_load),
    .len     (cfg_half),
    .expired (half_done)
  );

  cbw_shifter #(.WIDTH(BYTE_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (sh_load),
    .din   (cmd_byte),
    .step  (sh_step),
    .msb   (sh_msb),
    .last  (sh_last)
  );

  // Link pins are a decode of the state register only.
  assign idle_lvl  = ~cfg_clk_inv;
  assign selected  = (st == ST_SEL) || (st == ST_WMODE) || (st == ST_LOAD) ||
                     (st == ST_ACT) || (st == ST_REST)  || (st == ST_UNSTRB);
  assign wmode     = (st == ST_WMODE) || (st == ST_LOAD) ||
                     (st == ST_ACT)   || (st == ST_REST);
  assign shifting  = (st == ST_ACT) || (st == ST_REST);

  assign link_cs_n   = ~selected;
  assign link_strb   = ~wmode;
  assign link_sclk   = (st == ST_ACT) ? ~idle_lvl : idle_lvl;
  assign link_sdo    = shifting ? sh_msb : 1'b1;
  assign link_sdo_oe = wmode;
  assign busy        = (st != ST_IDLE);
endmodule

// File: rtl/cbw_checker.sv
module cbw_checker (
  input logic clk,
  input logic rst_n,
  input logic cmd_ready,
  input logic cfg_clk_inv,
  input logic abort,
  input logic busy,
  input logic link_cs_n,
  input logic link_strb,
  input logic link_sclk,
  input logic link_sdo,
  input logic link_sdo_oe
);
  AST_IDLE_CLK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    link_cs_n |-> (link_sclk == !cfg_clk_inv)); // R9

  AST_STRB_AFTER_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_strb) |-> (!link_cs_n && $past(!link_cs_n))); // R4

  AST_DESELECT_AFTER_STRB: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(link_cs_n) && !$past(abort)) |-> (link_strb && $past(link_strb))); // R10

  AST_SDO_HELD_AT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_cs_n && $past(!link_cs_n) && (link_sclk == !cfg_clk_inv) &&
     ($past(link_sclk) != !cfg_clk_inv)) |-> $stable(link_sdo)); // R3

  AST_DRIVE_ONLY_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    link_sdo_oe |-> (!link_strb && !link_cs_n)); // R5

  AST_READY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!link_cs_n && !link_strb && (link_sclk == !cfg_clk_inv))); // R12

  AST_ABORT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && busy) |=> (link_cs_n && link_strb && !link_sdo_oe)); // R11
endmodule

bind cfg_bit_writer cbw_checker u_cbw_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_ready   (cmd_ready),
  .cfg_clk_inv (cfg_clk_inv),
  .abort       (abort),
  .busy        (busy),
  .link_cs_n   (link_cs_n),
  .link_strb   (link_strb),
  .link_sclk   (link_sclk),
  .link_sdo    (link_sdo),
  .link_sdo_oe (link_sdo_oe)
);

// File: tb/tb_cfg_bit_writer.sv
module tb_cfg_bit_writer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_value = 1'b0;
  logic [6:0]  cmd_addr = '0;
  logic        cmd_precharge = 1'b0;
  logic [15:0] cfg_half = 16'd4;
  logic [7:0]  cfg_gap = 8'd3;
  logic        cfg_clk_inv = 1'b0;
  logic        abort = 1'b0;
  logic        busy, link_cs_n, link_strb, link_sclk, link_sdo, link_sdo_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  cfg_bit_writer dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_value(cmd_value), .cmd_addr(cmd_addr), .cmd_precharge(cmd_precharge),
    .cfg_half(cfg_half), .cfg_gap(cfg_gap), .cfg_clk_inv(cfg_clk_inv),
    .abort(abort), .busy(busy), .link_cs_n(link_cs_n), .link_strb(link_strb),
    .link_sclk(link_sclk), .link_sdo(link_sdo), .link_sdo_oe(link_sdo_oe)
  );

  always #10 clk = ~clk;

  // Peripheral model and edge timing monitor, sampled on the falling edge.
  int cyc = 0, cs_falls = 0, cap_n = 0, rx_n = 0, rx_bits = 0;
  int t_cs_fall = 0, t_strb_fall = 0, t_strb_rise = 0, t_cs_rise = 0;
  int t_busy_fall = 0, t_first_act = -1, act_run = 0, last_act_run = 0;
  int bad_ready = 0, bad_oe = 0;
  logic [7:0] rx_sh = '0;
  logic [7:0] rxq [16];
  logic p_sclk = 1'b1, p_cs = 1'b1, p_strb = 1'b1, p_busy = 1'b0;

  always @(negedge clk) begin
    logic idle_l;
    cyc++;
    idle_l = !cfg_clk_inv;
    if (rst_n) begin
      if (p_cs && !link_cs_n) begin
        cs_falls++; t_cs_fall = cyc; rx_bits = 0; t_first_act = -1;
      end
      if (p_strb && !link_strb) t_strb_fall = cyc;
      if (!p_strb && link_strb) t_strb_rise = cyc;
      if (!p_cs && link_cs_n)   t_cs_rise = cyc;
      if (p_busy && !busy)      t_busy_fall = cyc;
      if (link_sclk != idle_l) begin
        act_run++;
        if (t_first_act < 0) t_first_act = cyc;
      end else begin
        if (act_run > 0) last_act_run = act_run;
        act_run = 0;
      end
      if (!link_cs_n && !link_strb && p_sclk != idle_l && link_sclk == idle_l) begin
        cap_n++;
        rx_sh = {rx_sh[6:0], link_sdo};
        rx_bits++;
        if (rx_bits == 8) begin
          rxq[rx_n % 16] = rx_sh; rx_n++; rx_bits = 0;
        end
      end
      if (cmd_ready && (link_sclk != idle_l || link_cs_n)) bad_ready++;
      if (link_sdo_oe && (link_strb || link_cs_n)) bad_oe++;
    end
    p_sclk = link_sclk; p_cs = link_cs_n; p_strb = link_strb; p_busy = busy;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input logic v, input logic [6:0] a, input logic pre);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_value = v; cmd_addr = a; cmd_precharge = pre;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(link_cs_n == 1'b1, "R1 cs_n", int'(link_cs_n), 1);
    chk(link_strb == 1'b1, "R1 strb", int'(link_strb), 1);
    chk(link_sclk == 1'b1, "R1 sclk", int'(link_sclk), 1);
    chk(link_sdo_oe == 1'b0 && busy == 1'b0 && cmd_ready == 1'b0, "R1 oe/busy/ready",
        int'({link_sdo_oe, busy, cmd_ready}), 0);
  endtask

  task automatic t_single();
    int rx0 = rx_n, cap0 = cap_n;
    push(1'b1, 7'd47, 1'b0);
    wait_idle();
    chk(rx_n == rx0 + 1, "R2 byte count", rx_n - rx0, 1);
    chk(rxq[rx0 % 16] == 8'hAF, "R2 byte", int'(rxq[rx0 % 16]), 'hAF);
    chk(cap_n - cap0 == 8, "R3 pulses per byte", cap_n - cap0, 8);
    chk(t_strb_fall - t_cs_fall == 3, "R4 select to strobe", t_strb_fall - t_cs_fall, 3);
    chk(t_first_act - t_strb_fall == 4, "R4 strobe to clock", t_first_act - t_strb_fall, 4);
    chk(last_act_run == 4, "R6 active half", last_act_run, 4);
    chk(t_cs_rise - t_strb_rise == 3, "R10 strobe to deselect", t_cs_rise - t_strb_rise, 3);
    chk(t_busy_fall - t_cs_rise == 3, "R10 deselect to not busy", t_busy_fall - t_cs_rise, 3);
    chk(link_sdo_oe == 1'b0, "R5 released after burst", int'(link_sdo_oe), 0);
  endtask

  task automatic t_half();
    int rx0 = rx_n;
    cfg_half = 16'd2;
    push(1'b0, 7'h5A, 1'b0);
    wait_idle();
    chk(last_act_run == 2, "R6 active half 2", last_act_run, 2);
    chk(rxq[rx0 % 16] == 8'h5A, "R2 byte 0x5A", int'(rxq[rx0 % 16]), 'h5A);
    cfg_half = 16'd4;
  endtask

  task automatic t_burst();
    int rx0 = rx_n, cs0 = cs_falls;
    push(1'b1, 7'h2F, 1'b0);
    push(1'b0, 7'h11, 1'b0);
    push(1'b0, 7'h12, 1'b1);
    wait_idle();
    chk(cs_falls == cs0 + 1, "R7 one select period", cs_falls - cs0, 1);
    chk(rx_n == rx0 + 3, "R7 bytes in burst", rx_n - rx0, 3);
    chk(rxq[rx0 % 16] == 8'hAF, "R2 burst byte0", int'(rxq[rx0 % 16]), 'hAF);
    chk(rxq[(rx0 + 1) % 16] == 8'h11, "R2 burst byte1", int'(rxq[(rx0 + 1) % 16]), 'h11);
    chk(rxq[(rx0 + 2) % 16] == 8'hFF, "R8 precharge", int'(rxq[(rx0 + 2) % 16]), 'hFF);
  endtask

  task automatic t_polarity();
    int rx0 = rx_n;
    cfg_clk_inv = 1'b1;
    @(negedge clk);
    chk(link_sclk == 1'b0, "R9 idle low", int'(link_sclk), 0);
    push(1'b0, 7'h05, 1'b0);
    wait_idle();
    chk(rxq[rx0 % 16] == 8'h05, "R9 byte inverted clock", int'(rxq[rx0 % 16]), 'h05);
    chk(link_sclk == 1'b0, "R9 idle low after", int'(link_sclk), 0);
    cfg_clk_inv = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_abort();
    int rx0 = rx_n, cap0 = cap_n, rx1;
    push(1'b1, 7'h33, 1'b0);
    while (cap_n - cap0 < 3) @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk(link_cs_n == 1'b1 && link_strb == 1'b1, "R11 lines released",
        int'({link_cs_n, link_strb}), 3);
    chk(link_sdo_oe == 1'b0, "R11 driver off", int'(link_sdo_oe), 0);
    wait_idle();
    chk(rx_n == rx0, "R11 byte not completed", rx_n - rx0, 0);
    chk(t_busy_fall - t_cs_rise == 3, "R11 recovery hold", t_busy_fall - t_cs_rise, 3);
    rx1 = rx_n;
    push(1'b0, 7'h44, 1'b0);
    wait_idle();
    chk(rxq[rx1 % 16] == 8'h44, "R11 write after abort", int'(rxq[rx1 % 16]), 'h44);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_half();
    t_burst();
    t_polarity();
    t_abort();
    chk(bad_ready == 0, "R12 ready only at boundary", bad_ready, 0);
    chk(bad_oe == 0, "R5 drive only in write", bad_oe, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule